// File: doc/BRIEF.md
# Post-Update Scaled-Index Store Unit

This block executes one indexed store at a time. Each store writes to memory at the base register value as it stood before the operation. It then hands the requester a new base value to write back. The new value is the old base plus the index register shifted left by one more than a small shift field, so the index is scaled by 2, 4, 8 or 16. Four store sizes are supported: byte, halfword, word and doubleword.

A requester offers a store on the request port. The unit takes it only when it is idle. It then computes the write address, the byte strobes and the lane-aligned data, and the updated base value, and registers all four. It holds the memory write request steady until memory signals ready. In that same cycle it pulses the writeback strobe with the updated base value.

Top module: `postinc_store_unit`

## Requirements
- R1: While reset is asserted and right after it, `mem_valid` and `wb_valid` are 0 and `req_ready` is 1.
- R2: `mem_addr` equals the `req_base` value that was sampled when the store was accepted, not the updated base.
- R3: `wb_value` equals `req_base + (req_index << (req_shift + 1))` modulo 2^64, using the values sampled at acceptance.
- R4: The size encoding is 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. `mem_strb` sets bits `off` to `off+n-1`, where `off` is `mem_addr[2:0]` and `n` is the size in bytes. Bits past bit 7 are dropped.
- R5: The low `n` bytes of `req_src` appear in `mem_data`, with source byte k in lane `off+k` (lane j is bits 8j+7..8j). Bytes that would fall past lane 7 are dropped, and every lane with a clear strobe bit reads zero.
- R6: A store is accepted only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 while a store is pending, and request inputs presented during that time have no effect on the pending store.
- R7: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid`, `mem_addr`, `mem_data` and `mem_strb` keep their values into the next cycle.
- R8: `wb_valid` is 1 for exactly one cycle: the cycle in which `mem_valid` and `mem_ready` are both 1. It is never 1 while the store is stalled.
- R9: In the cycle after the write completes, `mem_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Store request offered |
| req_ready | output | 1 | Unit idle and able to accept |
| req_size | input | 2 | Store size code (0 = byte, 1 = half, 2 = word, 3 = double) |
| req_shift | input | 2 | Index scale field; the index is shifted by this value plus one |
| req_base | input | 64 | Base register value |
| req_index | input | 64 | Index register value |
| req_src | input | 64 | Source register value |
| mem_valid | output | 1 | Memory write request pending |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | 64 | Write address (the old base) |
| mem_data | output | 64 | Write data placed in byte lanes |
| mem_strb | output | 8 | Byte lane enables |
| wb_valid | output | 1 | Base writeback pulse |
| wb_value | output | 64 | Updated base value |

## Verification
A wrong size decode or a wrong lane offset shows on `mem_strb` and `mem_data` in the first cycle after acceptance, because the payload is registered at that edge. A fault in the scaled sum is hidden until the write completes, and then shows on `wb_value` in the same cycle as `wb_valid`. A faulty pending flag shows up in one of three ways: a request accepted while busy, which alters the held payload; a `wb_valid` pulse during a stall; or a request that is never released after `mem_ready`. Each of these shows within one cycle of the event that exposes it. The sweep covers every combination of size, shift and address offset, with stalls of varying length.

// File: rtl/psu_pkg.sv
package psu_pkg;
  localparam int unsigned PSU_XLEN  = 64;
  localparam int unsigned PSU_SIZEW = 2;
  localparam int unsigned PSU_SHW   = 2;

  typedef enum logic [PSU_SIZEW-1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } psu_size_e;
endpackage

// File: rtl/psu_ea_calc.sv
module psu_ea_calc #(
  parameter int unsigned XLEN = psu_pkg::PSU_XLEN,
  parameter int unsigned SHW  = psu_pkg::PSU_SHW
) (
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] index_i,
  input  logic [SHW-1:0]  shift_i,
  output logic [XLEN-1:0] ea_o
);
  function automatic logic [XLEN-1:0] scaled_sum(
    input logic [XLEN-1:0] b,
    input logic [XLEN-1:0] x,
    input logic [SHW-1:0]  s
  );
    return b + (x << (s + 1));
  endfunction

  assign ea_o = scaled_sum(base_i, index_i, shift_i);
endmodule

// File: rtl/psu_lane_pack.sv
module psu_lane_pack #(
  parameter int unsigned XLEN  = psu_pkg::PSU_XLEN,
  parameter int unsigned SIZEW = psu_pkg::PSU_SIZEW
) (
  input  logic [SIZEW-1:0]                 size_i,
  input  logic [$clog2(XLEN/8)-1:0]        off_i,
  input  logic [XLEN-1:0]                  src_i,
  output logic [XLEN/8-1:0]                strb_o,
  output logic [XLEN-1:0]                  data_o
);
  localparam int unsigned LANES = XLEN / 8;
  localparam int unsigned OFSW  = $clog2(LANES);

  function automatic int unsigned size_bytes(input logic [SIZEW-1:0] sz);
    case (psu_pkg::psu_size_e'(sz))
      psu_pkg::SZ_BYTE: return 1;
      psu_pkg::SZ_HALF: return 2;
      psu_pkg::SZ_WORD: return 4;
      default:          return 8;
    endcase
  endfunction

  logic [LANES-1:0] lane_keep;
  logic [XLEN-1:0]  bit_keep;
  int unsigned      nbytes;

  assign nbytes = size_bytes(size_i);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_keep[l]       = (l < nbytes);
    assign bit_keep[l*8 +: 8] = {8{lane_keep[l]}};
  end

  logic [OFSW+2:0] bit_shift;
  assign bit_shift = {off_i, 3'b000};

  assign strb_o = lane_keep << off_i;
  assign data_o = (src_i & bit_keep) << bit_shift;
endmodule

// File: rtl/psu_ctrl.sv
module psu_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic mem_ready,
  output logic busy_o,
  output logic accept_o,
  output logic done_o
);
  logic busy_q;

  assign accept_o = req_valid && !busy_q;
  assign done_o   = busy_q && mem_ready;
  assign busy_o   = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy_q <= 1'b0;
    else if (accept_o) busy_q <= 1'b1;
    else if (done_o)   busy_q <= 1'b0;
  end
endmodule

// File: rtl/postinc_store_unit.sv
module postinc_store_unit #(
  parameter int unsigned XLEN  = psu_pkg::PSU_XLEN,
  parameter int unsigned SIZEW = psu_pkg::PSU_SIZEW,
  parameter int unsigned SHW   = psu_pkg::PSU_SHW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SIZEW-1:0]  req_size,
  input  logic [SHW-1:0]    req_shift,
  input  logic [XLEN-1:0]   req_base,
  input  logic [XLEN-1:0]   req_index,
  input  logic [XLEN-1:0]   req_src,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [XLEN-1:0]   mem_addr,
  output logic [XLEN-1:0]   mem_data,
  output logic [XLEN/8-1:0] mem_strb,
  output logic              wb_valid,
  output logic [XLEN-1:0]   wb_value
);
  localparam int unsigned LANES = XLEN / 8;
  localparam int unsigned OFSW  = $clog2(LANES);

  logic             busy;
  logic             accept_evt;
  logic             done_evt;
  logic [XLEN-1:0]  ea_next;
  logic [LANES-1:0] strb_next;
  logic [XLEN-1:0]  data_next;

  logic [XLEN-1:0]  addr_q, data_q, ea_q;
  logic [LANES-1:0] strb_q;

  psu_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .mem_ready (mem_ready),
    .busy_o    (busy),
    .accept_o  (accept_evt),
    .done_o    (done_evt)
  );

  psu_ea_calc #(.XLEN(XLEN), .SHW(SHW)) u_ea (
    .base_i  (req_base),
    .index_i (req_index),
    .shift_i (req_shift),
    .ea_o    (ea_next)
  );

  psu_lane_pack #(.XLEN(XLEN), .SIZEW(SIZEW)) u_pack (
    .size_i (req_size),
    .off_i  (req_base[OFSW-1:0]),
    .src_i  (req_src),
    .strb_o (strb_next),
    .data_o (data_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      strb_q <= '0;
      ea_q   <= '0;
    end else if (accept_evt) begin
      addr_q <= req_base;
      data_q <= data_next;
      strb_q <= strb_next;
      ea_q   <= ea_next;
    end
  end

  assign req_ready = !busy;
  assign mem_valid = busy;
  assign mem_addr  = addr_q;
  assign mem_data  = data_q;
  assign mem_strb  = strb_q;
  assign wb_valid  = done_evt;
  assign wb_value  = ea_q;
endmodule

// File: rtl/psu_chk.sv
module psu_chk #(
  parameter int unsigned XLEN = psu_pkg::PSU_XLEN
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [XLEN-1:0]   mem_addr,
  input logic [XLEN-1:0]   mem_data,
  input logic [XLEN/8-1:0] mem_strb,
  input logic              wb_valid,
  input logic              accept_evt,
  input logic              done_evt
);
  localparam int unsigned OFSW = $clog2(XLEN / 8);

  function automatic logic [XLEN-1:0] lanes_to_bits(input logic [XLEN/8-1:0] s);
    logic [XLEN-1:0] m;
    for (int i = 0; i < XLEN; i++) m[i] = s[i/8];
    return m;
  endfunction

  // R6
  busy_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready);

  // R6
  accept_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> mem_valid);

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                   && $stable(mem_data) && $stable(mem_strb)));

  // R8
  no_wb_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ready |-> !wb_valid);

  // R8
  wb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (!mem_valid && req_ready));

  // R4
  first_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_strb[mem_addr[OFSW-1:0]]);

  // R5
  data_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> ((mem_data & ~lanes_to_bits(mem_strb)) == '0));
endmodule

bind postinc_store_unit psu_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_addr   (mem_addr),
  .mem_data   (mem_data),
  .mem_strb   (mem_strb),
  .wb_valid   (wb_valid),
  .accept_evt (accept_evt),
  .done_evt   (done_evt)
);

// File: tb/sim_postinc_store_unit.sv
module sim_postinc_store_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_size = '0;
  logic [1:0]  req_shift = '0;
  logic [63:0] req_base = '0;
  logic [63:0] req_index = '0;
  logic [63:0] req_src = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [63:0] mem_addr;
  logic [63:0] mem_data;
  logic [7:0]  mem_strb;
  logic        wb_valid;
  logic [63:0] wb_value;

  int checks = 0;
  int errors = 0;
  logic [63:0] lcg = 64'h1234_5678_9abc_def1;

  always #5 clk = ~clk;

  postinc_store_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_size(req_size), .req_shift(req_shift), .req_base(req_base),
    .req_index(req_index), .req_src(req_src), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_strb(mem_strb), .wb_valid(wb_valid), .wb_value(wb_value)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] next_rand();
    lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
    return lcg;
  endfunction

  task automatic do_store(input logic [1:0] sz, input logic [1:0] sh,
                          input logic [63:0] base, input logic [63:0] idx,
                          input logic [63:0] src, input int stall);
    logic [63:0] exp_ea, exp_data;
    logic [7:0]  exp_strb;
    int          nb, off;
    nb  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 8;
    off = int'(base[2:0]);
    exp_ea   = base + idx * (64'd2 << sh);
    exp_strb = '0;
    exp_data = '0;
    for (int i = 0; i < 8; i++) begin
      if (i >= off && (i - off) < nb) begin
        exp_strb[i]        = 1'b1;
        exp_data[i*8 +: 8] = src[(i-off)*8 +: 8];
      end
    end

    @(negedge clk);
    req_size = sz; req_shift = sh; req_base = base; req_index = idx;
    req_src = src; req_valid = 1'b1;
    chk(req_ready === 1'b1, "R6 ready when idle", {63'd0, req_ready}, 64'd1);
    @(posedge clk);
    #1;
    req_valid = 1'b1;
    req_base  = ~base; req_index = next_rand(); req_src = ~src;
    req_size  = ~sz;  req_shift = ~sh;
    chk(mem_valid === 1'b1, "R6 mem_valid after accept", {63'd0, mem_valid}, 64'd1);
    chk(req_ready === 1'b0, "R6 ready low while busy", {63'd0, req_ready}, 64'd0);
    chk(mem_addr === base, "R2 old base address", mem_addr, base);
    chk(mem_strb === exp_strb, "R4 strobe", {56'd0, mem_strb}, {56'd0, exp_strb});
    chk(mem_data === exp_data, "R5 lane data", mem_data, exp_data);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(wb_valid === 1'b0, "R8 no writeback in stall", {63'd0, wb_valid}, 64'd0);
      chk(mem_valid === 1'b1 && mem_addr === base && mem_data === exp_data
          && mem_strb === exp_strb, "R7 held while stalled", mem_addr, base);
      chk(mem_addr === base, "R6 busy inputs ignored", mem_addr, base);
    end
    @(negedge clk);
    req_valid = 1'b0;
    mem_ready = 1'b1;
    #1;
    chk(wb_valid === 1'b1, "R8 writeback pulse on completion", {63'd0, wb_valid}, 64'd1);
    chk(wb_value === exp_ea, "R3 updated base", wb_value, exp_ea);
    @(posedge clk);
    #1;
    mem_ready = 1'b0;
    chk(mem_valid === 1'b0, "R9 request released", {63'd0, mem_valid}, 64'd0);
    chk(req_ready === 1'b1, "R9 ready returns", {63'd0, req_ready}, 64'd1);
    chk(wb_valid === 1'b0, "R8 single-cycle pulse", {63'd0, wb_valid}, 64'd0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(mem_valid === 1'b0, "R1 mem_valid in reset", {63'd0, mem_valid}, 64'd0);
    chk(wb_valid === 1'b0, "R1 wb_valid in reset", {63'd0, wb_valid}, 64'd0);
    chk(req_ready === 1'b1, "R1 ready in reset", {63'd0, req_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_valid === 1'b0 && req_ready === 1'b1, "R1 idle after reset",
        {63'd0, mem_valid}, 64'd0);

    for (int sz = 0; sz < 4; sz++)
      for (int sh = 0; sh < 4; sh++)
        for (int off = 0; off < 8; off++) begin
          logic [63:0] b;
          b = {next_rand() & 64'hFFFF_FFFF_FFFF_FFF8} | 64'(off);
          do_store(2'(sz), 2'(sh), b, next_rand(), next_rand(), (sz + sh + off) % 3);
        end

    // R3: sum wraps modulo 2^64
    do_store(2'd3, 2'd3, 64'hFFFF_FFFF_FFFF_FFF8, 64'h8000_0000_0000_0001,
             64'h0102_0304_0506_0708, 0);
    // R4 / R5: doubleword at lane 7 keeps only one lane
    do_store(2'd3, 2'd0, 64'h0000_0000_0000_1007, 64'd0, 64'hAABB_CCDD_EEFF_1122, 4);
    // R3: zero index leaves the base unchanged
    do_store(2'd1, 2'd2, 64'h0000_0000_0000_2002, 64'd0, 64'h0000_0000_0000_BEEF, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule